// File: doc/BRIEF.md
# Clock Recovery Lock and Signal-Loss Supervisor

This block supervises a clock and data recovery loop. It measures the frequency of the recovered clock against a local reference clock, decides whether the external PLL should follow the reference or the incoming serial data, and reports lock. The recovered clock is first divided by the line-rate ratio: 32 for the 622.08 Mbps rate, or 8 for the 155.52 Mbps rate, from a 19.44 MHz reference. The divided clock is then counted over a fixed window of reference cycles. The count crosses into the reference domain through a toggle handshake. A three-state controller runs in the reference domain and moves between reference acquisition, data tracking and reference hold.

Two board-level inputs form a loss-of-signal condition: signal detect, which is active high, and force-to-reference, which is active low. Both are synchronized into the reference domain. While loss of signal holds, the PLL stays on the reference, lock is withheld and the serial data output is forced to zero. The mute is applied in the recovered-clock domain, so noise is never passed on as data.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While rst_ni is low, pll_sel_o is 0 (PLL follows the reference), lock_o is 0 and ser_data_o is 0.
- R2: A measurement window lasts 2^WIN_LOG2 reference cycles. A window is in tolerance when the divided recovered-clock count lies within TOL of 2^WIN_LOG2. The first result after reset is discarded.
- R3: The divide ratio is 32 when rate_hi_i is 1 and 8 when rate_hi_i is 0. A recovered clock at 32 times the reference is in tolerance only with rate_hi_i=1, and one at 8 times the reference only with rate_hi_i=0.
- R4: While tracking data (pll_sel_o=1), one out-of-tolerance window returns pll_sel_o and lock_o to 0 on the cycle after the result.
- R5: Loss of signal is asserted whenever sig_det_i is 0 or force_ref_ni is 0, after a two-flop synchronizer in the reference domain. When it is asserted, pll_sel_o goes to 0 on the next reference cycle.
- R6: While loss of signal is asserted, ser_data_o is 0. The mute takes effect within one recovered-clock cycle after the condition reaches the recovered-clock domain. Without loss of signal, ser_data_o repeats ser_data_i one recovered-clock cycle later.
- R7: lock_o is 1 exactly when the block is tracking data and loss of signal is deasserted, so lock_o=1 implies pll_sel_o=1.
- R8: Switching to data tracking happens only after GOOD_N (default 2) consecutive in-tolerance windows with loss of signal deasserted. This applies both after reset and after a fall back to the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Local reference clock |
| clk_rec_i | input | 1 | Recovered clock from the PLL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rate_hi_i | input | 1 | Rate select: 1 = divide by 32, 0 = divide by 8 |
| sig_det_i | input | 1 | Signal detect, active high |
| force_ref_ni | input | 1 | Force PLL to reference, active low |
| ser_data_i | input | 1 | Retimed serial data |
| ser_data_o | output | 1 | Serial data, muted to 0 on loss of signal |
| lock_o | output | 1 | Lock indication |
| pll_sel_o | output | 1 | PLL source: 1 = incoming data, 0 = reference |

## Verification
Frequency decisions arrive once per window, a few reference cycles after each window edge because of the handshake. The bench therefore samples acquisition midway between result edges: about 2.5 windows after reset the block must still be on the reference, and by 3.5 windows it must be tracking. Changes of frequency or rate are given four windows, enough for one mixed window followed by two clean ones. Loss-of-signal effects take two reference flops plus one state register, and the mute takes two recovered-clock flops plus the data register. These checks wait ten reference cycles, and all outputs are sampled on the falling reference edge.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;
  typedef enum logic [1:0] {
    ST_REF_ACQ    = 2'd0,
    ST_DATA_TRACK = 2'd1,
    ST_REF_HOLD   = 2'd2
  } lock_state_e;
endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cdr_freq_meter.sv
module cdr_freq_meter #(
  parameter int unsigned WIN_LOG2 = 14,
  parameter int unsigned TOL      = 8,
  parameter int unsigned DIV_HI   = 32,
  parameter int unsigned DIV_LO   = 8
) (
  input  logic clk_ref_i,
  input  logic clk_rec_i,
  input  logic rst_ni,
  input  logic rate_hi_i,
  output logic valid_o,
  output logic ok_o
);
  localparam int unsigned CW = WIN_LOG2 + 2;
  localparam int unsigned PW = $clog2(DIV_HI);
  localparam logic [CW-1:0] WIN_V = CW'(1) << WIN_LOG2;
  localparam logic [CW-1:0] LO_V  = WIN_V - CW'(TOL);
  localparam logic [CW-1:0] HI_V  = WIN_V + CW'(TOL);

  // reference domain: window timer
  logic [WIN_LOG2-1:0] win_cnt_q;
  logic                win_tgl_q;

  always_ff @(posedge clk_ref_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      win_tgl_q <= 1'b0;
    end else begin
      win_cnt_q <= win_cnt_q + 1'b1;
      if (&win_cnt_q) win_tgl_q <= ~win_tgl_q;
    end
  end

  // recovered domain: prescaler, counter, snapshot
  logic          win_s, win_d_q, done_tgl_q;
  logic [PW-1:0] pre_cnt_q, ratio_m1;
  logic          pre_tc;
  logic [CW-1:0] div_cnt_q, snap_q;

  cdr_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_win_sync (
    .clk_i(clk_rec_i), .rst_ni(rst_ni), .d_i(win_tgl_q), .q_o(win_s)
  );

  assign ratio_m1 = rate_hi_i ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
  assign pre_tc   = (pre_cnt_q >= ratio_m1);

  always_ff @(posedge clk_rec_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q  <= '0;
      div_cnt_q  <= '0;
      snap_q     <= '0;
      win_d_q    <= 1'b0;
      done_tgl_q <= 1'b0;
    end else begin
      pre_cnt_q <= pre_tc ? '0 : pre_cnt_q + 1'b1;
      win_d_q   <= win_s;
      if (win_s ^ win_d_q) begin
        snap_q     <= div_cnt_q;
        div_cnt_q  <= CW'(pre_tc);
        done_tgl_q <= ~done_tgl_q;
      end else if (pre_tc && !(&div_cnt_q)) begin
        div_cnt_q <= div_cnt_q + 1'b1;
      end
    end
  end

  // reference domain: result pickup; snap_q is stable for a whole window
  logic done_s, done_d_q, seen_q, valid_q, ok_q, done_edge;

  cdr_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_done_sync (
    .clk_i(clk_ref_i), .rst_ni(rst_ni), .d_i(done_tgl_q), .q_o(done_s)
  );

  assign done_edge = done_s ^ done_d_q;

  always_ff @(posedge clk_ref_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_d_q <= 1'b0;
      seen_q   <= 1'b0;
      valid_q  <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      done_d_q <= done_s;
      seen_q   <= seen_q | done_edge;
      valid_q  <= done_edge & seen_q;
      ok_q     <= (snap_q >= LO_V) && (snap_q <= HI_V);
    end
  end

  assign valid_o = valid_q;
  assign ok_o    = ok_q;
endmodule

// File: rtl/cdr_lock_fsm.sv
module cdr_lock_fsm
  import cdr_lock_pkg::*;
#(
  parameter int unsigned GOOD_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic meas_valid_i,
  input  logic meas_ok_i,
  input  logic los_i,
  output logic track_o,
  output logic lock_o
);
  localparam int unsigned GW = $clog2(GOOD_N + 1);

  lock_state_e   state_q, state_d;
  logic [GW-1:0] good_q, good_d;
  logic          good_win;

  assign good_win = meas_valid_i && meas_ok_i && !los_i;

  always_comb begin
    state_d = state_q;
    good_d  = good_q;
    if (los_i) good_d = '0;
    else if (meas_valid_i) good_d = meas_ok_i ? good_q + 1'b1 : '0;
    unique case (state_q)
      ST_DATA_TRACK: begin
        good_d = '0;
        if (los_i || (meas_valid_i && !meas_ok_i)) state_d = ST_REF_HOLD;
      end
      ST_REF_ACQ, ST_REF_HOLD: begin
        if (good_win && (good_q == GW'(GOOD_N - 1))) begin
          state_d = ST_DATA_TRACK;
          good_d  = '0;
        end
      end
      default: state_d = ST_REF_ACQ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_REF_ACQ;
      good_q  <= '0;
    end else begin
      state_q <= state_d;
      good_q  <= good_d;
    end
  end

  assign track_o = (state_q == ST_DATA_TRACK);
  assign lock_o  = track_o && !los_i;
endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl #(
  parameter int unsigned WIN_LOG2 = 14,
  parameter int unsigned TOL      = 8,
  parameter int unsigned DIV_HI   = 32,
  parameter int unsigned DIV_LO   = 8,
  parameter int unsigned GOOD_N   = 2
) (
  input  logic clk_ref_i,
  input  logic clk_rec_i,
  input  logic rst_ni,
  input  logic rate_hi_i,
  input  logic sig_det_i,
  input  logic force_ref_ni,
  input  logic ser_data_i,
  output logic ser_data_o,
  output logic lock_o,
  output logic pll_sel_o
);
  logic sig_s, force_s, los_ref, los_rec;
  logic meas_valid, meas_ok;
  logic data_q;

  cdr_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_sig_sync (
    .clk_i(clk_ref_i), .rst_ni(rst_ni), .d_i(sig_det_i), .q_o(sig_s)
  );
  cdr_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_force_sync (
    .clk_i(clk_ref_i), .rst_ni(rst_ni), .d_i(force_ref_ni), .q_o(force_s)
  );

  assign los_ref = !sig_s || !force_s;

  cdr_freq_meter #(
    .WIN_LOG2(WIN_LOG2), .TOL(TOL), .DIV_HI(DIV_HI), .DIV_LO(DIV_LO)
  ) u_meter (
    .clk_ref_i(clk_ref_i), .clk_rec_i(clk_rec_i), .rst_ni(rst_ni),
    .rate_hi_i(rate_hi_i), .valid_o(meas_valid), .ok_o(meas_ok)
  );

  cdr_lock_fsm #(.GOOD_N(GOOD_N)) u_fsm (
    .clk_i(clk_ref_i), .rst_ni(rst_ni), .meas_valid_i(meas_valid),
    .meas_ok_i(meas_ok), .los_i(los_ref), .track_o(pll_sel_o), .lock_o(lock_o)
  );

  // mute path in the recovered domain, muted out of reset
  cdr_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_los_sync (
    .clk_i(clk_rec_i), .rst_ni(rst_ni), .d_i(los_ref), .q_o(los_rec)
  );

  always_ff @(posedge clk_rec_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= 1'b0;
    else         data_q <= ser_data_i && !los_rec;
  end

  assign ser_data_o = data_q;
endmodule

// File: rtl/cdr_lock_ctrl_chk.sv
module cdr_lock_ctrl_chk (
  input logic clk_ref_i,
  input logic clk_rec_i,
  input logic rst_ni,
  input logic lock_o,
  input logic pll_sel_o,
  input logic ser_data_o,
  input logic los_ref,
  input logic los_rec,
  input logic meas_valid,
  input logic meas_ok
);
  a_r7_lock_needs_track: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    lock_o |-> pll_sel_o);

  a_r5_los_leaves_track: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    los_ref |=> !pll_sel_o);

  a_r8_enter_on_good_win: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    $rose(pll_sel_o) |-> $past(meas_valid && meas_ok && !los_ref));

  a_r4_bad_win_exits: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (pll_sel_o && meas_valid && !meas_ok) |=> !pll_sel_o);

  a_r6_mute_data: assert property (@(posedge clk_rec_i) disable iff (!rst_ni)
    los_rec |=> !ser_data_o);
endmodule

bind cdr_lock_ctrl cdr_lock_ctrl_chk u_chk (
  .clk_ref_i(clk_ref_i), .clk_rec_i(clk_rec_i), .rst_ni(rst_ni),
  .lock_o(lock_o), .pll_sel_o(pll_sel_o), .ser_data_o(ser_data_o),
  .los_ref(los_ref), .los_rec(los_rec),
  .meas_valid(meas_valid), .meas_ok(meas_ok)
);

// File: tb/tb_cdr_lock_ctrl.sv
`timescale 1ps/100fs
module tb_cdr_lock_ctrl;
  localparam int WIN_LOG2 = 10;
  localparam int WIN      = 1 << WIN_LOG2;
  localparam real REF_HALF = 2000.0;

  logic clk_ref = 1'b0, clk_rec = 1'b0, rst_n = 1'b0;
  logic rate_hi = 1'b1, sig_det = 1'b1, force_n = 1'b1, din = 1'b1;
  logic dout, lock, pll_sel;
  real  rec_half = 62.5;
  int   total = 0, bad = 0;
  bit   finished = 1'b0;

  always #(REF_HALF) clk_ref = ~clk_ref;
  always #(rec_half) clk_rec = ~clk_rec;

  cdr_lock_ctrl #(.WIN_LOG2(WIN_LOG2), .TOL(8)) dut (
    .clk_ref_i(clk_ref), .clk_rec_i(clk_rec), .rst_ni(rst_n),
    .rate_hi_i(rate_hi), .sig_det_i(sig_det), .force_ref_ni(force_n),
    .ser_data_i(din), .ser_data_o(dout), .lock_o(lock), .pll_sel_o(pll_sel)
  );

  // freq_sel: 0 nominal, 1 fast, 2 slow; line ratio picked independently
  function automatic real half_for(bit hi_line, int freq_sel);
    real base = hi_line ? 62.5 : 250.0;
    if (freq_sel == 1) return base * 0.95;
    if (freq_sel == 2) return base * 1.05;
    return base;
  endfunction

  function automatic bit exp_track(bit los, bit in_tol);
    return !los && in_tol;
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ref(int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic check_all(string req, bit los, bit in_tol, logic d);
    check({req, " pll_sel"}, pll_sel, exp_track(los, in_tol));
    check({req, " lock"}, lock, exp_track(los, in_tol));
    check({req, " data"}, dout, los ? 1'b0 : d);
  endtask

  initial begin
    wait_ref(3);
    check("R1 pll_sel", pll_sel, 1'b0);
    check("R1 lock", lock, 1'b0);
    check("R1 data", dout, 1'b0);
    rst_n = 1'b1;

    // R2/R8: one usable window is not enough, two are
    wait_ref(WIN * 5 / 2);
    check("R2 R8 still on ref", pll_sel, 1'b0);
    wait_ref(WIN);
    check_all("R2 R7 acquired", 1'b0, 1'b1, 1'b1);

    // R5 force alone, R6 mute, R7
    force_n = 1'b0;
    wait_ref(10);
    check_all("R5 R6 R7 force", 1'b1, 1'b1, 1'b1);
    force_n = 1'b1;
    wait_ref(4 * WIN + 20);
    check_all("R8 back after force", 1'b0, 1'b1, 1'b1);

    // R5 signal detect alone
    sig_det = 1'b0;
    wait_ref(10);
    check_all("R5 R6 sigd low", 1'b1, 1'b1, 1'b1);
    sig_det = 1'b1;
    wait_ref(4 * WIN + 20);
    check_all("R8 back after sigd", 1'b0, 1'b1, 1'b1);

    // R4 frequency out of window
    rec_half = half_for(1'b1, 1);
    wait_ref(2 * WIN + 20);
    check_all("R4 fast clock", 1'b0, 1'b0, 1'b1);
    rec_half = half_for(1'b1, 0);
    wait_ref(4 * WIN + 20);
    check_all("R8 recovered", 1'b0, 1'b1, 1'b1);

    // R3 wrong rate select, then matching line clock
    rate_hi = 1'b0;
    wait_ref(2 * WIN + 20);
    check_all("R3 ratio mismatch", 1'b0, 1'b0, 1'b1);
    rec_half = half_for(1'b0, 0);
    wait_ref(4 * WIN + 20);
    check_all("R3 low rate lock", 1'b0, 1'b1, 1'b1);

    // random mix
    void'($urandom(32'h5eed_c0de));
    for (int t = 0; t < 10; t++) begin
      bit hi_line = $urandom_range(0, 1);
      bit rsel    = ($urandom_range(0, 3) == 0) ? !hi_line : hi_line;
      int fsel    = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 2) : 0;
      bit s       = ($urandom_range(0, 3) != 0);
      bit f       = ($urandom_range(0, 3) != 0);
      bit d       = $urandom_range(0, 1);
      rec_half = half_for(hi_line, fsel);
      rate_hi  = rsel;
      sig_det  = s;
      force_n  = f;
      din      = d;
      wait_ref(4 * WIN + 20);
      check_all("R3 R4 R5 R6 R7 R8 random", !(s && f),
                (fsel == 0) && (rsel == hi_line), d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_ref);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule